// File: doc/BRIEF.md
# Sandwich Ping-Pong Transpose Buffer

This block turns a row-major stream of M x N blocks into a column-major stream. It is the transpose stage that sits between two one-dimensional transform passes. A full double buffer needs two M x N banks. This block instead keeps two banks of (M-P) x N cells, ping and pong, and one shared bar of P x N cells. The last P rows of every block go into the shared bar, whichever bank holds the rest of that block.

A source writes one cell per cycle while `in_valid_i` is high. The first M-P rows go to the active bank and the last P rows go to the shared bar. The active bank switches after every block. After each block the write side ignores input for `IDLE_GAP` cycles. That gap gives the previous block's reads of the shared bar time to finish before the next block writes to those cells again.

The read side starts on its own `INIT_DLY` cycles after the first cell of a block is accepted. It then issues M*N reads without a break. Each column is read top to bottom: its bank cells first, then its shared-bar cells, then the next column. Both timing values are parameters whose defaults are computed from M, N and P. For M=4, N=4, P=1 the defaults are a 13-cycle start delay and a 1-cycle gap.

Top module: `sandwich_pingpong`

## Requirements
- R1: After reset `out_valid_o` is low, and it stays low until a cell that has been written is read.
- R2: Within a block, output item j equals input item (j mod M)*N + (j div M). Input items are counted row-major from 0 and output items from 0, so columns come out in order 0..N-1 and each column runs from row 0 to row M-1.
- R3: The first output of a block is valid exactly `INIT_DLY`+1 cycles after the cycle in which that block's first cell is accepted (13+1 for the default 4x4, P=1 configuration). The M*N outputs of the block follow on consecutive cycles.
- R4: Rows 0..M-P-1 of a block are stored in the bank that alternates between successive blocks, and rows M-P..M-1 go to the single shared bar. Blocks written back to back, each separated only by the idle gap, all come out transposed and intact.
- R5: For the `IDLE_GAP` cycles that follow the last cell of a block (1 cycle by default), `in_valid_i` is ignored and no cell is written.
- R6: `in_data_i` has no effect while `in_valid_i` is low.
- R7: No read ever targets a cell that has not been written since it was last read.
- R8: No write ever overwrites a cell whose previous contents have not yet been read.
- R9: Each block produces exactly M*N valid outputs. `out_valid_o` is low whenever no written block is waiting to be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input cell present this cycle |
| in_data_i | input | DW | Input cell, row-major order |
| out_valid_o | output | 1 | Output cell present this cycle |
| out_data_o | output | DW | Output cell, column-major order |

## Verification
The bound checker tracks whether each cell of the ping bank, the pong bank and the shared bar holds unread data. On every cycle it checks that no read hits an empty cell, that no write hits a full one, and that nothing is written during the idle gap. It also checks that output runs always end on a whole number of blocks. Only the bench scenarios can show the transposed ordering of the data, the exact start latency, and that junk inputs in the gap or with valid low leave no trace. They cover a lone block, three back-to-back blocks with junk driven in the gaps, and a late block after a long pause.

// File: rtl/spp_pkg.sv
package spp_pkg;

  typedef enum logic [1:0] {
    REG_PING = 2'd0,
    REG_PONG = 2'd1,
    REG_BAR  = 2'd2
  } region_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // start delay: long enough that a column read never overtakes the row-major write
  function automatic int default_delay(int m, int n, int p);
    int d;
    d = imax((m - p) * n + 1, (m - 1) * (n - 1) + 1);
    return imax(d, 2);
  endfunction

  // gap after each block: bar rows of block k must be read before block k+1 rewrites them
  function automatic int default_gap(int m, int n, int p);
    int d;
    d = default_delay(m, n, p);
    return imax(imax(p * n - (m - p), d - m * n + (n - 1) * (p - 1) + 1), 0);
  endfunction

  function automatic region_e region_of(int row, logic bank, int m, int p);
    if (row >= m - p) return REG_BAR;
    return bank ? REG_PONG : REG_PING;
  endfunction

  function automatic int region_addr(int row, int col, int m, int n, int p);
    return ((row >= m - p) ? row - (m - p) : row) * n + col;
  endfunction

endpackage

// File: rtl/spp_region.sv
module spp_region #(
  parameter int DW    = 8,
  parameter int DEPTH = 12,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/spp_wr_ctrl.sv
module spp_wr_ctrl
  import spp_pkg::*;
#(
  parameter int M    = 4,
  parameter int N    = 4,
  parameter int P    = 1,
  parameter int IDLE = 1,
  parameter int AW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          wr_en_o,
  output region_e       wr_sel_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          blk_start_o
);

  localparam int RW = (M > 1) ? $clog2(M) : 1;
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam int GW = $clog2(IDLE + 2);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          bank_q;
  logic [GW-1:0] gap_q;
  logic          last_col, last_row;

  assign wr_en_o     = in_valid_i && (gap_q == '0);
  assign last_col    = (col_q == CW'(N - 1));
  assign last_row    = (row_q == RW'(M - 1));
  assign blk_start_o = wr_en_o && (row_q == '0) && (col_q == '0);
  assign wr_sel_o    = region_of(int'(row_q), bank_q, M, P);
  assign wr_addr_o   = AW'(region_addr(int'(row_q), int'(col_q), M, N, P));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= 1'b0;
      gap_q  <= '0;
    end else if (wr_en_o) begin
      if (last_col) begin
        col_q <= '0;
        if (last_row) begin
          row_q  <= '0;
          bank_q <= ~bank_q;
          gap_q  <= GW'(IDLE);
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        col_q <= col_q + 1'b1;
      end
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

endmodule

// File: rtl/spp_rd_ctrl.sv
module spp_rd_ctrl
  import spp_pkg::*;
#(
  parameter int M        = 4,
  parameter int N        = 4,
  parameter int P        = 1,
  parameter int INIT_DLY = 13,
  parameter int AW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blk_start_i,
  output logic          rd_en_o,
  output region_e       rd_sel_o,
  output logic [AW-1:0] rd_addr_o
);

  localparam int RW  = (M > 1) ? $clog2(M) : 1;
  localparam int CW  = (N > 1) ? $clog2(N) : 1;
  localparam int DLW = $clog2(INIT_DLY + 1);

  logic           arm_q, busy_q, bank_q, fire, last_row, last_cell;
  logic [DLW-1:0] dly_q;
  logic [RW-1:0]  row_q;
  logic [CW-1:0]  col_q;

  assign fire      = arm_q && (dly_q == DLW'(INIT_DLY - 1));
  assign last_row  = (row_q == RW'(M - 1));
  assign last_cell = busy_q && last_row && (col_q == CW'(N - 1));
  assign rd_en_o   = busy_q;
  assign rd_sel_o  = region_of(int'(row_q), bank_q, M, P);
  assign rd_addr_o = AW'(region_addr(int'(row_q), int'(col_q), M, N, P));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      dly_q <= '0;
    end else if (blk_start_i) begin
      arm_q <= 1'b1;
      dly_q <= DLW'(1);
    end else if (fire) begin
      arm_q <= 1'b0;
    end else if (arm_q) begin
      dly_q <= dly_q + 1'b1;
    end
  end

  // column-major walk: row advances fastest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bank_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      if (fire) busy_q <= 1'b1;
      else if (last_cell) busy_q <= 1'b0;
      if (last_cell) bank_q <= ~bank_q;
      if (busy_q) begin
        if (last_row) begin
          row_q <= '0;
          col_q <= (col_q == CW'(N - 1)) ? '0 : col_q + 1'b1;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sandwich_pingpong.sv
module sandwich_pingpong
  import spp_pkg::*;
#(
  parameter int M        = 4,
  parameter int N        = 4,
  parameter int P        = 1,
  parameter int DW       = 8,
  parameter int INIT_DLY = spp_pkg::default_delay(M, N, P),
  parameter int IDLE_GAP = spp_pkg::default_gap(M, N, P)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o
);

  localparam int BANK_CELLS = (M - P) * N;
  localparam int BAR_CELLS  = P * N;
  localparam int DMAX       = (BANK_CELLS > BAR_CELLS) ? BANK_CELLS : BAR_CELLS;
  localparam int AW         = (DMAX > 1) ? $clog2(DMAX) : 1;

  logic          wr_en, rd_en, blk_start;
  region_e       wr_sel, rd_sel, sel_q;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] rdata [3];
  logic          vld_q;

  spp_wr_ctrl #(.M(M), .N(N), .P(P), .IDLE(IDLE_GAP), .AW(AW)) u_wr (
    .clk_i, .rst_ni, .in_valid_i,
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_addr_o(wr_addr), .blk_start_o(blk_start)
  );

  spp_rd_ctrl #(.M(M), .N(N), .P(P), .INIT_DLY(INIT_DLY), .AW(AW)) u_rd (
    .clk_i, .rst_ni, .blk_start_i(blk_start),
    .rd_en_o(rd_en), .rd_sel_o(rd_sel), .rd_addr_o(rd_addr)
  );

  // region 0 = ping, 1 = pong, 2 = shared bar
  for (genvar g = 0; g < 3; g++) begin : g_region
    localparam int DEPTH = (g == 2) ? BAR_CELLS : BANK_CELLS;
    spp_region #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk_i,
      .we_i   (wr_en && (int'(wr_sel) == g)),
      .waddr_i(wr_addr),
      .wdata_i(in_data_i),
      .re_i   (rd_en && (int'(rd_sel) == g)),
      .raddr_i(rd_addr),
      .rdata_o(rdata[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      sel_q <= REG_PING;
    end else begin
      vld_q <= rd_en;
      if (rd_en) sel_q <= rd_sel;
    end
  end

  assign out_valid_o = vld_q;

  always_comb begin
    case (sel_q)
      REG_PONG: out_data_o = rdata[1];
      REG_BAR:  out_data_o = rdata[2];
      default:  out_data_o = rdata[0];
    endcase
  end

endmodule

// File: rtl/spp_checker.sv
module spp_checker #(
  parameter int M    = 4,
  parameter int N    = 4,
  parameter int P    = 1,
  parameter int IDLE = 1,
  parameter int AW   = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    wr_sel_i,
  input logic [AW-1:0] wr_addr_i,
  input logic          rd_en_i,
  input logic [1:0]    rd_sel_i,
  input logic [AW-1:0] rd_addr_i,
  input logic          out_valid_i
);

  localparam int MN   = M * N;
  localparam int BC   = (M - P) * N;
  localparam int DMAX = (BC > P * N) ? BC : P * N;

  logic [3*DMAX-1:0] full_q;
  int wi, ri, wcnt_q, gap_q, run_q;
  logic seen_wr_q;

  assign wi = int'(wr_sel_i) * DMAX + int'(wr_addr_i);
  assign ri = int'(rd_sel_i) * DMAX + int'(rd_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q    <= '0;
      wcnt_q    <= 0;
      gap_q     <= 0;
      run_q     <= 0;
      seen_wr_q <= 1'b0;
    end else begin
      if (rd_en_i) full_q[ri] <= 1'b0;
      if (wr_en_i) full_q[wi] <= 1'b1;
      if (wr_en_i) begin
        seen_wr_q <= 1'b1;
        wcnt_q    <= (wcnt_q == MN - 1) ? 0 : wcnt_q + 1;
        if (wcnt_q == MN - 1) gap_q <= IDLE;
      end else if (gap_q != 0) begin
        gap_q <= gap_q - 1;
      end
      run_q <= out_valid_i ? run_q + 1 : 0;
    end
  end

  assert_rd_written_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> full_q[ri]);

  assert_wr_unread_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_q[wi]);

  assert_gap_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (gap_q == 0));

  assert_whole_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_i) |-> ((run_q % MN) == 0));

  assert_quiet_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> seen_wr_q);

endmodule

bind sandwich_pingpong spp_checker #(.M(M), .N(N), .P(P), .IDLE(IDLE_GAP), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en),
  .wr_sel_i   (wr_sel),
  .wr_addr_i  (wr_addr),
  .rd_en_i    (rd_en),
  .rd_sel_i   (rd_sel),
  .rd_addr_i  (rd_addr),
  .out_valid_i(out_valid_o)
);

// File: tb/sandwich_pingpong_bench.sv
module sandwich_pingpong_bench;

  localparam int M = 4, N = 4, P = 1, DW = 8;
  localparam int MN = M * N;
  localparam int D_EXP = 13;   // R3 default start delay
  localparam int GAP_EXP = 1;  // R5 default gap

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [DW-1:0] out_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  int start_q[$];
  logic prev_v = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sandwich_pingpong #(.M(M), .N(N), .P(P), .DW(DW)) u_sandwich_pingpong (
    .clk_i(clk), .rst_ni, .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] cell_val(int base, int idx);
    return DW'(base + idx * 5);
  endfunction

  // drives one block row-major, then the gap; pushes expected column-major output
  task automatic send_block(int base, bit junk_gap, string tag);
    start_q.push_back(cyc + D_EXP + 1);
    for (int j = 0; j < MN; j++) begin
      exp_q.push_back(cell_val(base, (j % M) * N + (j / M)));
      tag_q.push_back(tag);
    end
    for (int i = 0; i < MN; i++) begin
      in_valid = 1'b1;
      in_data  = cell_val(base, i);
      @(posedge clk); #1;
    end
    for (int g = 0; g < GAP_EXP; g++) begin
      in_valid = junk_gap;
      in_data  = 8'hEE;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle_noise(int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      in_data  = DW'(8'h5A ^ i);
      @(posedge clk); #1;
    end
  endtask

  task automatic drain_check(string req);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, req, int'(out_valid), 0);
    check(start_q.size() == 0, req, start_q.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (out_valid && !prev_v) begin
        if (start_q.size() == 0) check(1'b0, "R9", 1, 0);
        else begin
          int s;
          s = start_q.pop_front();
          check(cyc == s, "R3", cyc, s);
        end
      end
      if (out_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R9", 1, 0);
        else begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, int'(out_data), int'(e));
        end
      end
      prev_v <= out_valid;
    end
  end

  task automatic run();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    end
    @(posedge clk); #1;
    idle_noise(6);                           // R6: data toggles with valid low
    send_block(10, 1'b0, "R2");
    idle_noise(30);                          // R6
    drain_check("R9");
    send_block(40, 1'b1, "R4/R5");           // junk in gaps must be ignored
    send_block(90, 1'b1, "R4/R5");
    send_block(150, 1'b1, "R4/R5");
    idle_noise(40);
    send_block(200, 1'b0, "R6");
    idle_noise(3);
    drain_check("R9");
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule